// File: doc/BRIEF.md
# Byte-Addressed Word Memory Port

This block connects a processor core to a synchronous SRAM that is one 16-bit word wide. The core sees a flat space of 65536 bytes. The memory sees a word address and one enable per byte lane. Each load or store from the core becomes exactly one word transaction on the memory side, whether it moves one byte or a whole word.

Words are held big-endian. The even byte address carries bits [15:8] of the word, and the odd address that follows carries bits [7:0]. A byte store drives only the lane that the address selects, so the neighbouring byte in the same word is preserved. A byte load zero-fills the upper half of the returned value. A word access must use an even address. If it does not, no memory transaction is issued and the completion is flagged as misaligned.

The memory-side request is presented in the same cycle as the core's strobe, so the SRAM samples it on the next edge. Completion is reported by a one-cycle ready pulse after that edge, together with the formatted load data. A new request may be presented in the same cycle as the previous completion.

Top module: `bytemem_port`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, cpu_ready and cpu_misalign are low and cpu_rdata is zero.
- R2: During a request, mem_addr equals the core byte address shifted right by one bit. Address bit 0 is the byte offset inside the word.
- R3: An aligned word store drives mem_be = 2'b11 and puts the write data unchanged on mem_wdata. Bits [15:8] therefore land at the even byte and bits [7:0] at the odd byte.
- R4: A byte store to an even address drives mem_be = 2'b10 with cpu_wdata[7:0] on mem_wdata[15:8]. A byte store to an odd address drives mem_be = 2'b01 with cpu_wdata[7:0] on mem_wdata[7:0]. The other byte of the stored word is left unchanged, and cpu_wdata[15:8] is ignored.
- R5: An aligned word load returns the stored word. A byte load returns mem_rdata[15:8] for an even address or mem_rdata[7:0] for an odd address, in bits [7:0], with bits [15:8] zero.
- R6: Every request, read or write, is followed one clock later by cpu_ready high for exactly one cycle.
- R7: A word access with address bit 0 set leaves mem_en and mem_we low and changes no memory. cpu_misalign is then high in the same cycle as its ready pulse.
- R8: cpu_rdata is zero in every cycle that is not the completion of an aligned load, including store completions and misaligned completions.
- R9: When read and write strobes are both high, the request is treated as a store, and its completion returns zero data.
- R10: A request presented in the cycle where the previous one completes is accepted without a gap, and its ready pulse follows one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Byte address from the core |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_rd | input | 1 | Load strobe |
| cpu_wr | input | 1 | Store strobe |
| cpu_wdata | input | 16 | Store data (byte stores use bits [7:0]) |
| cpu_rdata | output | 16 | Formatted load data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_misalign | output | 1 | Word access to an odd address, flagged with cpu_ready |
| mem_addr | output | 15 | SRAM word address |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_be | output | 2 | Byte enables, bit 1 = bits [15:8] |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | SRAM read data, one cycle after the enable |

## Verification
Two functions can fall in the same cycle: the completion of one access, with its ready pulse and load formatting driven by registered state, and the decoding of a fresh request on the memory side. The bench provokes this by issuing a word store and, in its completion cycle, a byte load of the odd byte of that same word. It judges the overlap by requiring a second ready pulse one clock later and the newly written low byte, zero-extended, on the read data. Misaligned word accesses are also placed between good stores and loads of the same word, so that a blocked store shows up as unchanged data on the next read.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/bmp_req_decode.sv
module bmp_req_decode
  import bmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        narrow,
  input  logic                        rd,
  input  logic                        wr,
  output acc_kind_e                   kind,
  output logic                        misaligned,
  output logic [ADDR_W-LANE_BITS-1:0] word_addr,
  output logic [LANE_BITS-1:0]        offset
);
  // A store wins when both strobes are high.
  always_comb begin
    if (wr)      kind = ACC_STORE;
    else if (rd) kind = ACC_LOAD;
    else         kind = ACC_IDLE;
  end

  assign offset     = addr[LANE_BITS-1:0];
  assign word_addr  = addr[ADDR_W-1:LANE_BITS];
  assign misaligned = (kind != ACC_IDLE) && !narrow && (offset != '0);
endmodule

// File: rtl/bmp_store_steer.sv
module bmp_store_steer #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic                 active,
  input  logic                 narrow,
  input  logic [LANE_BITS-1:0] offset,
  input  logic [DATA_W-1:0]    wdata,
  output logic [LANES-1:0]     be,
  output logic [DATA_W-1:0]    lane_wdata
);
  // Big-endian: byte offset k lives in lane LANES-1-k.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int OFF = LANES - 1 - i;
    logic hit;
    assign hit = (offset == OFF[LANE_BITS-1:0]);
    assign be[i] = active && (narrow ? hit : 1'b1);
    assign lane_wdata[i*8 +: 8] = narrow ? wdata[7:0] : wdata[i*8 +: 8];
  end
endmodule

// File: rtl/bmp_load_select.sv
module bmp_load_select #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic                 valid,
  input  logic                 narrow,
  input  logic [LANE_BITS-1:0] offset,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [DATA_W-1:0]    rdata
);
  logic [7:0] byte_v;

  always_comb begin
    byte_v = '0;
    for (int i = 0; i < LANES; i++) begin
      if (offset == LANE_BITS'(LANES - 1 - i)) byte_v = mem_rdata[i*8 +: 8];
    end
    if (!valid)      rdata = '0;
    else if (narrow) rdata = {{(DATA_W-8){1'b0}}, byte_v};
    else             rdata = mem_rdata;
  end
endmodule

// File: rtl/bytemem_port.sv
module bytemem_port
  import bmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - LANE_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_byte,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_ready,
  output logic               cpu_misalign,
  output logic [WADDR_W-1:0] mem_addr,
  output logic               mem_en,
  output logic               mem_we,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  acc_kind_e            kind;
  logic                 misaligned;
  logic [LANE_BITS-1:0] offset;
  logic                 issue;

  // Completion state for the access the SRAM is serving.
  logic                 ready_q;
  logic                 fault_q;
  logic                 load_q;
  logic                 narrow_q;
  logic [LANE_BITS-1:0] off_q;

  bmp_req_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) decode_i (
    .addr       (cpu_addr),
    .narrow     (cpu_byte),
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .kind       (kind),
    .misaligned (misaligned),
    .word_addr  (mem_addr),
    .offset     (offset)
  );

  assign issue  = (kind != ACC_IDLE) && !misaligned;
  assign mem_en = issue;
  assign mem_we = issue && (kind == ACC_STORE);

  bmp_store_steer #(.DATA_W(DATA_W)) steer_i (
    .active     (issue),
    .narrow     (cpu_byte),
    .offset     (offset),
    .wdata      (cpu_wdata),
    .be         (mem_be),
    .lane_wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b0;
      fault_q  <= 1'b0;
      load_q   <= 1'b0;
      narrow_q <= 1'b0;
      off_q    <= '0;
    end else begin
      ready_q  <= (kind != ACC_IDLE);
      fault_q  <= misaligned;
      load_q   <= issue && (kind == ACC_LOAD);
      narrow_q <= cpu_byte;
      off_q    <= offset;
    end
  end

  bmp_load_select #(.DATA_W(DATA_W)) select_i (
    .valid     (load_q),
    .narrow    (narrow_q),
    .offset    (off_q),
    .mem_rdata (mem_rdata),
    .rdata     (cpu_rdata)
  );

  assign cpu_ready    = ready_q;
  assign cpu_misalign = fault_q;
endmodule

// File: rtl/bytemem_port_chk.sv
module bytemem_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_byte,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_ready,
  input logic              cpu_misalign,
  input logic              mem_en,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be
);
  logic req, odd_word;
  assign req      = cpu_rd || cpu_wr;
  assign odd_word = req && !cpu_byte && (cpu_addr[LANE_BITS-1:0] != '0);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_ready && !cpu_misalign && cpu_rdata == '0));

  assert_word_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_byte && !odd_word) |-> (&mem_be));

  assert_byte_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (req && cpu_byte) |-> ($countones(mem_be) == 1));

  assert_ready_follows_R6: assert property (@(posedge clk) disable iff (rst)
    req |=> cpu_ready);

  assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
    !req |=> !cpu_ready);

  assert_odd_word_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    odd_word |-> (!mem_en && !mem_we));

  assert_odd_word_flag_R7: assert property (@(posedge clk) disable iff (rst)
    odd_word |=> (cpu_misalign && cpu_ready));

  assert_rdata_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !cpu_ready |-> (cpu_rdata == '0));
endmodule

bind bytemem_port bytemem_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cpu_addr     (cpu_addr),
  .cpu_byte     (cpu_byte),
  .cpu_rd       (cpu_rd),
  .cpu_wr       (cpu_wr),
  .cpu_rdata    (cpu_rdata),
  .cpu_ready    (cpu_ready),
  .cpu_misalign (cpu_misalign),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .mem_be       (mem_be)
);

// File: tb/bytemem_port_tb_top.sv
module bytemem_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_byte = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_ready, cpu_misalign;
  logic [14:0] mem_addr;
  logic        mem_en, mem_we;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  bytemem_port dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_byte(cpu_byte),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_misalign(cpu_misalign),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Small synchronous SRAM model with byte enables (bit 1 = [15:8]).
  logic [15:0] bram [256];
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we && mem_be[1]) bram[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
      if (mem_we && mem_be[0]) bram[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
      mem_rdata <= bram[mem_addr[7:0]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_byte = 1'b0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  // Fields: [51] rd, [50] wr, [49] byte, [48:33] addr, [32:17] wdata,
  //         [16:1] expected rdata, [0] expected misalign.
  localparam int NV = 17;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 16'h0010, 16'h1234, 16'h0000, 1'b0},  // R3 word store
    {1'b1, 1'b0, 1'b0, 16'h0010, 16'h0000, 16'h1234, 1'b0},  // R5 word load
    {1'b1, 1'b0, 1'b1, 16'h0010, 16'h0000, 16'h0012, 1'b0},  // R3 even byte = high
    {1'b1, 1'b0, 1'b1, 16'h0011, 16'h0000, 16'h0034, 1'b0},  // R5 odd byte = low
    {1'b0, 1'b1, 1'b1, 16'h0011, 16'h00AB, 16'h0000, 1'b0},  // R4 odd byte store
    {1'b1, 1'b0, 1'b0, 16'h0010, 16'h0000, 16'h12AB, 1'b0},  // R4 neighbour kept
    {1'b0, 1'b1, 1'b1, 16'h0010, 16'h99CD, 16'h0000, 1'b0},  // R4 upper wdata ignored
    {1'b1, 1'b0, 1'b0, 16'h0010, 16'h0000, 16'hCDAB, 1'b0},  // R4 even byte store
    {1'b0, 1'b1, 1'b0, 16'h0012, 16'h5566, 16'h0000, 1'b0},  // R3
    {1'b0, 1'b1, 1'b0, 16'h0013, 16'hFFFF, 16'h0000, 1'b1},  // R7 odd word store
    {1'b1, 1'b0, 1'b0, 16'h0012, 16'h0000, 16'h5566, 1'b0},  // R7 memory unchanged
    {1'b1, 1'b0, 1'b0, 16'h0013, 16'h0000, 16'h0000, 1'b1},  // R7 R8 odd word load
    {1'b0, 1'b1, 1'b1, 16'h0013, 16'h0077, 16'h0000, 1'b0},  // R4 odd byte legal
    {1'b1, 1'b0, 1'b0, 16'h0012, 16'h0000, 16'h5577, 1'b0},  // R5
    {1'b1, 1'b1, 1'b0, 16'h0020, 16'hBEEF, 16'h0000, 1'b0},  // R9 both strobes
    {1'b1, 1'b0, 1'b0, 16'h0020, 16'h0000, 16'hBEEF, 1'b0},  // R9 store happened
    {1'b1, 1'b0, 1'b1, 16'h0021, 16'h0000, 16'h00EF, 1'b0}   // R5
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(cpu_ready), 32'd0);
    chk("R1 misalign in reset", 32'(cpu_misalign), 32'd0);
    chk("R1 rdata in reset", 32'(cpu_rdata), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(cpu_ready), 32'd0);
    chk("R1 rdata after reset", 32'(cpu_rdata), 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic        e_rd, e_wr, e_byte, e_mis;
      logic [15:0] e_addr, e_wd, e_rdata;
      logic [1:0]  e_be;
      {e_rd, e_wr, e_byte, e_addr, e_wd, e_rdata, e_mis} = VEC[v];
      e_be = e_byte ? (e_addr[0] ? 2'b01 : 2'b10) : 2'b11;
      cpu_rd = e_rd; cpu_wr = e_wr; cpu_byte = e_byte;
      cpu_addr = e_addr; cpu_wdata = e_wd;
      #1;
      chk("R2 word address", 32'(mem_addr), 32'(e_addr[15:1]));
      chk("R7 mem_en", 32'(mem_en), 32'(!e_mis));
      chk("R7 R9 mem_we", 32'(mem_we), 32'(e_wr && !e_mis));
      if (!e_mis) chk("R3 R4 byte enables", 32'(mem_be), 32'(e_be));
      if (!e_mis && e_wr && e_byte)
        chk("R4 steered lane", 32'(e_addr[0] ? mem_wdata[7:0] : mem_wdata[15:8]),
            32'(e_wd[7:0]));
      @(negedge clk);
      chk("R6 ready pulse", 32'(cpu_ready), 32'd1);
      chk("R7 misalign flag", 32'(cpu_misalign), 32'(e_mis));
      chk("R5 R8 rdata", 32'(cpu_rdata), 32'(e_rdata));
      idle();
      @(negedge clk);
      chk("R6 single-cycle ready", 32'(cpu_ready), 32'd0);
      chk("R8 idle rdata", 32'(cpu_rdata), 32'd0);
    end

    // R10: back-to-back store then byte load of the same word
    cpu_wr = 1'b1; cpu_addr = 16'h0030; cpu_wdata = 16'hA5C3;
    @(negedge clk);
    chk("R10 first ready", 32'(cpu_ready), 32'd1);
    chk("R10 store rdata", 32'(cpu_rdata), 32'd0);
    cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_byte = 1'b1; cpu_addr = 16'h0031;
    #1;
    chk("R10 second request issued", 32'(mem_en), 32'd1);
    @(negedge clk);
    chk("R10 second ready", 32'(cpu_ready), 32'd1);
    chk("R10 load data", 32'(cpu_rdata), 32'h00C3);
    idle();
    @(negedge clk);
    chk("R10 ready drops", 32'(cpu_ready), 32'd0);

    // R2: top of the byte space
    cpu_rd = 1'b1; cpu_byte = 1'b1; cpu_addr = 16'hFFFF;
    #1;
    chk("R2 top address", 32'(mem_addr), 32'h7FFF);
    chk("R4 top odd lane", 32'(mem_be), 32'b01);
    @(negedge clk);
    chk("R6 top ready", 32'(cpu_ready), 32'd1);
    idle();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule